// File: doc/BRIEF.md
# Host-Serviced Watchdog Interlock

This block is a register-mapped watchdog placed behind a simple synchronous bus. The bus has a select strobe, a 4-bit offset, a write enable, 16-bit write data and combinational read data. Host software must read the status word at regular intervals. Each such read restarts a seconds counter. If the host stops reading, the counter reaches the programmed timeout and the block latches a FAIL state. It then releases its inhibit output and hands the high-voltage enable line to an outside system by passing the synchronized external enable straight through.

A state machine has three states. ST_FAIL is the reset state. ST_HOLD means the clear bit is held and counting is frozen. ST_RUN means the counter is live. The transitions are:
- FORCE: any state goes to ST_FAIL on a status write with bit 1 set.
- RELEASE: any state goes to ST_HOLD on a status write with bit 0 set and bit 1 clear.
- EXPIRE: ST_RUN or ST_HOLD goes to ST_FAIL when the timeout is zero. ST_RUN also goes to ST_FAIL when the counter has reached the timeout.
- ARM: ST_HOLD goes to ST_RUN on a status write with bits 1 and 0 clear.

A prescaler makes a one-cycle tick each second from the clock frequency parameter. The counter advances only on ticks in ST_RUN. A stretched select pulse drives an access indicator.

Top module: `wdog_interlock`

## Requirements
- R1: A read at offset 0 or offset 1 returns 16'h002E. Writes to those offsets change nothing that can be read back.
- R2: After reset, offset 2 reads 16'h0018 with the external enable high, or 16'h0008 with it low. Offset 3 reads 0. fail_out is 1, inhibit_out is 0 and hv_ctrl_led is 0.
- R3: The status word at offset 2 is laid out as follows. Bit 0 is clear-held (state ST_HOLD). Bit 1 is force-set, the last written bit 1. Bit 2 is inhibit. Bit 3 is FAIL. Bit 4 is the synchronized external enable. Upper bits read 0. In ST_RUN, a read of offset 2 restarts the counter, so FAIL never occurs while reads come less than (T-1) seconds apart.
- R4: In ST_RUN with timeout T>0 and no reads, FAIL is set one cycle after the counter reaches T. The counter counts prescaler ticks, one every CLK_HZ cycles.
- R5: A timeout value of zero sends ST_RUN or ST_HOLD to ST_FAIL without any tick.
- R6: A write to offset 2 with bit 1 set forces FAIL at once, whatever the other bits hold. Bit 1 then reads 1 and inhibit reads 0.
- R7: A write to offset 2 with bit 0 set (bit 1 clear) clears FAIL and holds the counter. A later write with bits 1:0 = 0 starts counting, and its bit 2 sets inhibit.
- R8: Entering FAIL clears inhibit. inhibit_out is never 1 while FAIL is set.
- R9: A timeout-caused FAIL returns status bits 2:0 to 0 and leaves the timeout register (offset 3, read/write) unchanged.
- R10: hv_en_out equals FAIL AND the two-flop-synchronized hv_en_in. hv_ctrl_led is the inverse of FAIL.
- R11: sel_led goes high the cycle after any select and stays high for at least STRETCH cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_sel is high |
| hv_en_in | input | 1 | External high-voltage enable (asynchronous) |
| hv_en_out | output | 1 | Enable handed on while FAIL is set |
| inhibit_out | output | 1 | Inhibit request to the outside system |
| fail_out | output | 1 | FAIL flag |
| hv_ctrl_led | output | 1 | High while the host holds control |
| sel_led | output | 1 | Stretched access indicator |

## Verification
The watchdog is driven with randomly spaced status reads. Every gap is short enough that FAIL must never appear, which separates a counter that restarts on reads from one that does not. A directed silent period then checks that expiry lands inside the exact cycle window that one to two prescaler periods of phase uncertainty allow. That check separates correct tick counting from off-by-one and missing-tick faults. Directed cases cover zero timeout in both ST_HOLD and ST_RUN, a forced FAIL that arrives with inhibit already set, the full release handshake, and the external enable pass-through at both levels.

// File: rtl/wdi_pkg.sv
package wdi_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 4;
    localparam logic [DATA_W-1:0] BOARD_ID = 16'h002E;

    localparam logic [ADDR_W-1:0] OFS_ID0 = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_ID1 = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_CSR = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_TMO = 4'd3;

    typedef enum logic [1:0] {
        ST_FAIL = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } wd_state_t;
endpackage

// File: rtl/wdi_sync.sv
module wdi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/wdi_prescaler.sv
module wdi_prescaler #(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_HZ - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else if (div_q == LAST) begin
            div_q <= '0;
            tick  <= 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    generate
        if (CLK_HZ > 1) begin : g_chk
            AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R4
        end
    endgenerate
endmodule

// File: rtl/wdi_stretch.sv
module wdi_stretch #(
    parameter int unsigned STRETCH = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic led
);
    localparam int unsigned SW = $clog2(STRETCH + 1);
    localparam logic [SW-1:0] LOAD = SW'(STRETCH);

    logic [SW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n)           left_q <= '0;
        else if (pulse)       left_q <= LOAD;
        else if (left_q != 0) left_q <= left_q - 1'b1;
    end

    assign led = (left_q != '0);

    AST_SEL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> led); // R11
endmodule

// File: rtl/wdi_core.sv
module wdi_core
    import wdi_pkg::*;
#(
    parameter int unsigned TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_csr,
    input  logic              wr_tmo,
    input  logic              rd_csr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic              fail_o,
    output logic              clr_o,
    output logic              set_o,
    output logic              inh_o,
    output logic [TMO_W-1:0]  tmo_o
);
    wd_state_t        state_q, state_nx;
    logic [TMO_W-1:0] cnt_q, tmo_q;
    logic             set_q, inh_q;
    logic             expire, force_fail, release_clr;

    assign force_fail  = wr_csr && wdata[1];
    assign release_clr = wr_csr && wdata[0] && !wdata[1];
    assign expire      = (state_q != ST_FAIL) &&
                         ((tmo_q == '0) || (state_q == ST_RUN && cnt_q >= tmo_q));

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_FAIL: begin
                if (release_clr) state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (force_fail)       state_nx = ST_FAIL;
                else if (release_clr) state_nx = ST_HOLD;
                else if (expire)      state_nx = ST_FAIL;
                else if (wr_csr)      state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (force_fail)       state_nx = ST_FAIL;
                else if (release_clr) state_nx = ST_HOLD;
                else if (expire)      state_nx = ST_FAIL;
            end
            default: state_nx = ST_FAIL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FAIL;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= 1'b0;
            inh_q <= 1'b0;
            cnt_q <= '0;
            tmo_q <= '0;
        end else begin
            if (wr_tmo) tmo_q <= wdata[TMO_W-1:0];

            if (wr_csr)                 set_q <= wdata[1];
            else if (state_nx == ST_FAIL && state_q != ST_FAIL)
                                        set_q <= 1'b0;

            if (state_nx == ST_FAIL)    inh_q <= 1'b0;
            else if (wr_csr)            inh_q <= wdata[2];

            if (state_nx != ST_RUN || state_q != ST_RUN || rd_csr)
                cnt_q <= '0;
            else if (tick && cnt_q != '1)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fail_o = (state_q == ST_FAIL);
    assign clr_o  = (state_q == ST_HOLD);
    assign set_o  = set_q;
    assign inh_o  = inh_q;
    assign tmo_o  = tmo_q;

    AST_FAIL_NO_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !inh_o); // R8
    AST_HIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_csr |=> (cnt_q == '0)); // R3
    AST_ZERO_TMO_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (!fail_o && tmo_q == '0 && !wr_csr) |=> fail_o); // R5
    AST_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tmo_q != '0 && cnt_q >= tmo_q && !wr_csr) |=> fail_o); // R4
    AST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        force_fail |=> (fail_o && set_o)); // R6
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt_q == '0)); // R7
    AST_WD_KEEPS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !wr_csr && !wr_tmo) |=> (tmo_q == $past(tmo_q) && !set_o && !clr_o)); // R9
endmodule

// File: rtl/wdog_interlock.sv
module wdog_interlock
    import wdi_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned STRETCH = 1_000_000,
    parameter int unsigned TMO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hv_en_in,
    output logic              hv_en_out,
    output logic              inhibit_out,
    output logic              fail_out,
    output logic              hv_ctrl_led,
    output logic              sel_led
);
    logic             hv_sync, tick;
    logic             wr_csr, wr_tmo, rd_csr;
    logic             fail, clr, set_b, inh;
    logic [TMO_W-1:0] tmo;

    assign wr_csr = bus_sel &&  bus_we && (bus_addr == OFS_CSR);
    assign wr_tmo = bus_sel &&  bus_we && (bus_addr == OFS_TMO);
    assign rd_csr = bus_sel && !bus_we && (bus_addr == OFS_CSR);

    wdi_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(hv_en_in), .d_out(hv_sync)
    );

    wdi_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    wdi_stretch #(.STRETCH(STRETCH)) u_led (
        .clk(clk), .rst_n(rst_n), .pulse(bus_sel), .led(sel_led)
    );

    wdi_core #(.TMO_W(TMO_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .wr_csr(wr_csr), .wr_tmo(wr_tmo), .rd_csr(rd_csr),
        .wdata(bus_wdata), .tick(tick),
        .fail_o(fail), .clr_o(clr), .set_o(set_b), .inh_o(inh), .tmo_o(tmo)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            unique case (bus_addr)
                OFS_ID0, OFS_ID1: bus_rdata = BOARD_ID;
                OFS_CSR:          bus_rdata = DATA_W'({hv_sync, fail, inh, set_b, clr});
                OFS_TMO:          bus_rdata = DATA_W'(tmo);
                default:          bus_rdata = '0;
            endcase
        end
    end

    assign hv_en_out   = fail & hv_sync;
    assign inhibit_out = inh;
    assign fail_out    = fail;
    assign hv_ctrl_led = ~fail;

    AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        !fail_out |-> !hv_en_out); // R10
    AST_LED_INV: assert property (@(posedge clk) disable iff (!rst_n)
        hv_ctrl_led != fail_out); // R10
endmodule

// File: tb/tb_wdog_interlock.sv
module tb_wdog_interlock;
    localparam int CLK_PERIOD = 10;
    localparam int HZ = 8;
    localparam int STR = 4;

    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0, bus_rdata;
    logic        hv_en_in = 1;
    logic        hv_en_out, inhibit_out, fail_out, hv_ctrl_led, sel_led;

    int n_chk = 0, n_bad = 0;
    logic [15:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_interlock #(.CLK_HZ(HZ), .STRETCH(STR), .TMO_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hv_en_in(hv_en_in), .hv_en_out(hv_en_out), .inhibit_out(inhibit_out),
        .fail_out(fail_out), .hv_ctrl_led(hv_ctrl_led), .sel_led(sel_led)
    );

    function automatic logic [15:0] exp_csr(input bit clr, input bit set,
                                            input bit inh, input bit fl, input bit hv);
        return {11'd0, hv, fl, inh, set, clr};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rdreg(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #(CLK_PERIOD/4);
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic recover(input logic [15:0] t, input logic [15:0] last);
        wr(4'd3, t);
        wr(4'd2, 16'h0001);
        wr(4'd2, last);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1;
        idle(3);

        // R2 reset image
        rdreg(4'd2, rd); check("R2 csr", rd, exp_csr(0,0,0,1,1));
        rdreg(4'd3, rd); check("R2 tmo", rd, 16'h0000);
        check("R2 outs", {15'd0, fail_out, inhibit_out, hv_ctrl_led} , {15'd0, 1'b1, 1'b0, 1'b0});
        check("R10 pass-through high", {15'd0, hv_en_out}, 16'd1);

        // R1 ID and ignored writes
        rdreg(4'd0, rd); check("R1 id0", rd, 16'h002E);
        wr(4'd1, 16'hFFFF); wr(4'd0, 16'h0000);
        rdreg(4'd1, rd); check("R1 id1 after write", rd, 16'h002E);
        rdreg(4'd0, rd); check("R1 id0 after write", rd, 16'h002E);
        rdreg(4'd2, rd); check("R1 csr untouched", rd, exp_csr(0,0,0,1,1));

        // R10 external enable low
        hv_en_in = 0; idle(3);
        check("R10 pass-through low", {15'd0, hv_en_out}, 16'd0);
        rdreg(4'd2, rd); check("R2 csr hv low", rd, exp_csr(0,0,0,1,0));
        hv_en_in = 1; idle(3);

        // R5 zero timeout in HOLD
        wr(4'd2, 16'h0001); idle(3);
        rdreg(4'd2, rd); check("R5 zero tmo in hold", rd, exp_csr(0,0,0,1,1));

        // R7 release handshake
        wr(4'd3, 16'd3); wr(4'd2, 16'h0001);
        rdreg(4'd2, rd); check("R7 hold", rd, exp_csr(1,0,0,0,1));
        check("R10 host control", {14'd0, hv_ctrl_led, hv_en_out}, 16'b10);
        idle(5*HZ);
        rdreg(4'd2, rd); check("R7 frozen in hold", rd, exp_csr(1,0,0,0,1));
        wr(4'd2, 16'h0004);
        rdreg(4'd2, rd); check("R7 run with inhibit", rd, exp_csr(0,0,1,0,1));
        check("R7 inhibit pin", {15'd0, inhibit_out}, 16'd1);

        // R3 random hitting, gaps below (T-1)*HZ
        for (int i = 0; i < 40; i++) begin
            int gap = 1 + int'($urandom % ((3-1)*HZ - 3));
            idle(gap);
            if ($urandom % 4 == 0) begin
                rdreg(4'd1, rd); check("R1 id random", rd, 16'h002E);
            end
            rdreg(4'd2, rd);
            check("R3 alive while hit", rd, exp_csr(0,0,1,0,1));
        end

        // R4/R8/R9 silent expiry
        idle(2*HZ - 2);
        check("R4 not yet expired", {15'd0, fail_out}, 16'd0);
        idle(HZ + 6);
        check("R4 expired", {15'd0, fail_out}, 16'd1);
        check("R8 inhibit dropped", {15'd0, inhibit_out}, 16'd0);
        rdreg(4'd2, rd); check("R9 csr reset image", rd, exp_csr(0,0,0,1,1));
        rdreg(4'd3, rd); check("R9 tmo kept", rd, 16'd3);

        // R4 exact window with T=2
        recover(16'd2, 16'h0000);
        begin
            int cyc = 0;
            rdreg(4'd2, rd);
            while (!fail_out && cyc < 40) begin
                @(negedge clk); cyc++;
            end
            // read edge was one cycle before the loop started
            check("R4 expiry window", 16'(((cyc+1) >= 10 && (cyc+1) <= 17) ? 1 : 0), 16'd1);
        end

        // R6 forced FAIL with inhibit on
        recover(16'd5, 16'h0004);
        check("R6 pre inhibit", {15'd0, inhibit_out}, 16'd1);
        wr(4'd2, 16'h0007);
        rdreg(4'd2, rd); check("R6 forced", rd, exp_csr(0,1,0,1,1));
        check("R8 inhibit after force", {15'd0, inhibit_out}, 16'd0);

        // R5 zero timeout in RUN
        recover(16'd5, 16'h0000);
        check("R5 running", {15'd0, fail_out}, 16'd0);
        wr(4'd3, 16'd0); idle(2);
        check("R5 zero tmo in run", {15'd0, fail_out}, 16'd1);

        // R11 stretched select
        idle(STR + 2);
        check("R11 idle low", {15'd0, sel_led}, 16'd0);
        wr(4'd0, 16'h0000);
        check("R11 lit", {15'd0, sel_led}, 16'd1);
        idle(STR - 2);
        check("R11 still lit", {15'd0, sel_led}, 16'd1);
        idle(3);
        check("R11 off", {15'd0, sel_led}, 16'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule